// File: doc/BRIEF.md
# DMA Interrupt Status Unit with Access Filtering

This block keeps the event flags of a multi-channel DMA controller and raises one interrupt line per channel. For every channel the transfer engine pulses three event inputs (half transfer, transfer complete, transfer error). Each pulse latches a sticky flag. A per-channel global flag is formed as the OR of the three. Software sees the flags through a read-only status word and drops them through a write-only clear word, both on a 32-bit register port.

Each channel carries a secure-mode bit and a privileged-mode bit, supplied as inputs. Every register access carries secure and privileged attributes. A read returns the fields only of channels that the access may see, and zero for all others. A clear is applied only to channels that the access is trusted enough to touch. The interrupt line of a channel is driven when a flag is set and its enable input is high.

The register port is plain control: a request is taken in the cycle `req_valid` is high and is never stalled. A read answers one cycle later with `rsp_valid` high and `rsp_rdata`, so there is no back-pressure on either side.

Top module: `dma_irq_status`

## Requirements
- R1: After reset every flag is clear, every interrupt line is low and a status read returns 0.
- R2: An event pulse in cycle t sets its flag, seen from cycle t+1, whatever the channel's secure and privileged mode.
- R3: The status word (byte offset 0x0) holds channel c (0-based) in bits 4c+3..4c: bit 4c is the global flag (OR of the other three), bit 4c+1 transfer complete, bit 4c+2 half transfer, bit 4c+3 transfer error; bits 31:28 read 0. Read data appears in the cycle after the request.
- R4: A non-secure read (`req_secure`=0) returns 0 in all four bits of every channel whose `ch_secure` is 1; a secure read returns every channel.
- R5: An unprivileged read (`req_priv`=0) returns 0 in all four bits of every channel whose `ch_priv` is 1; a privileged read returns every channel.
- R6: Writing 1 to bit 4c+1, 4c+2 or 4c+3 of the clear word (byte offset 0x4) clears only that one flag of channel c; other flags keep their value.
- R7: Writing 1 to bit 4c of the clear word clears all three flags of channel c.
- R8: A clear on channel c is applied only if the access is secure when `ch_secure[c]`=1 and privileged when `ch_priv[c]`=1; otherwise the flags of c are unchanged.
- R9: `irq[c]` is 1 exactly when some flag of channel c is 1 with its enable (`en_tc`, `en_ht`, `en_te`) high; the global flag has no enable of its own.
- R10: When an event and a permitted clear hit the same flag in the same cycle, the flag ends set.
- R11: An access with `req_be` other than 4'b1111 is ignored for a write and returns 0 for a read.
- R12: Reading the clear word returns 0, writing 0 bits to it changes nothing, and writing the status word changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_ht | input | 7 | Half-transfer event pulse per channel |
| evt_tc | input | 7 | Transfer-complete event pulse per channel |
| evt_te | input | 7 | Transfer-error event pulse per channel |
| ch_secure | input | 7 | Channel is in secure mode |
| ch_priv | input | 7 | Channel is in privileged mode |
| en_ht | input | 7 | Half-transfer interrupt enable per channel |
| en_tc | input | 7 | Transfer-complete interrupt enable per channel |
| en_te | input | 7 | Transfer-error interrupt enable per channel |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 4 | Byte offset of the access (0x0 status, 0x4 clear) |
| req_be | input | 4 | Byte enables; only 4'b1111 is a valid access |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Access is secure |
| req_priv | input | 1 | Access is privileged |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| irq | output | 7 | Interrupt line per channel |

## Verification
Directed patterns place flags on channels with every mix of secure and privileged modes and then read and clear them with each of the four access attribute pairs, which tells masking by the secure rule apart from masking by the privileged rule, and a permitted clear from a denied one. Single-bit clears are set against global clears on a channel holding two flags, to show the individual bits act alone. An event coinciding with a clear, partial byte enables, reads of the clear word and writes to the status word each target one corner. A long seeded random run then mixes events, modes, enables and accesses so that sets, clears, masks and interrupt lines interact in patterns the directed cases do not reach.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int FLD_W      = 4;    // bits per channel in status and clear words
  localparam int BIT_GLB    = 0;    // global flag / global clear position in a field
  localparam int NUM_EVT    = 3;    // event kinds: 0 complete, 1 half, 2 error
  localparam int STATUS_OFS = 0;
  localparam int CLEAR_OFS  = 4;
endpackage

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_EVT-1:0][NUM_CH-1:0]  set_i,
  input  logic [NUM_EVT-1:0][NUM_CH-1:0]  clr_i,
  output logic [NUM_EVT-1:0][NUM_CH-1:0]  flag_o
);

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_kind
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk) begin
        if (!rst_n) flag_o[k][c] <= 1'b0;
        else        flag_o[k][c] <= set_i[k][c] | (flag_o[k][c] & ~clr_i[k][c]);
      end

      // R10: an event wins over a clear in the same cycle
      p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[k][c] |=> flag_o[k][c]);

      // R6: without set or clear a flag keeps its value
      p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i[k][c] && !clr_i[k][c]) |=> (flag_o[k][c] == $past(flag_o[k][c])));
    end
  end

endmodule

// File: rtl/dma_irq_access.sv
module dma_irq_access
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [DATA_W/8-1:0]             req_be,
  input  logic [DATA_W-1:0]               req_wdata,
  input  logic                            req_secure,
  input  logic                            req_priv,
  input  logic [NUM_CH-1:0]               ch_secure,
  input  logic [NUM_CH-1:0]               ch_priv,
  input  logic [NUM_EVT-1:0][NUM_CH-1:0]  flag_i,
  output logic [NUM_EVT-1:0][NUM_CH-1:0]  clr_o,
  output logic                            rsp_valid,
  output logic [DATA_W-1:0]               rsp_rdata
);

  localparam int USED_W = NUM_CH * FLD_W;

  logic              full_word;
  logic              hit_clear;
  logic              hit_status;
  logic [NUM_CH-1:0] allow;
  logic [DATA_W-1:0] status_word;

  assign full_word  = &req_be;
  assign hit_clear  = req_valid &  req_write & full_word & (req_addr == ADDR_W'(CLEAR_OFS));
  assign hit_status = req_valid & ~req_write & full_word & (req_addr == ADDR_W'(STATUS_OFS));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign allow[c] = (req_secure | ~ch_secure[c]) & (req_priv | ~ch_priv[c]);

    for (genvar k = 0; k < NUM_EVT; k++) begin : g_kind
      assign clr_o[k][c] = hit_clear & allow[c] &
                           (req_wdata[c*FLD_W + BIT_GLB] | req_wdata[c*FLD_W + 1 + k]);
    end

    always_comb begin
      status_word[c*FLD_W +: FLD_W] = '0;
      if (allow[c]) begin
        status_word[c*FLD_W + BIT_GLB] = |{flag_i[2][c], flag_i[1][c], flag_i[0][c]};
        for (int k = 0; k < NUM_EVT; k++)
          status_word[c*FLD_W + 1 + k] = flag_i[k][c];
      end
    end

    // R3: global bit in a response is the OR of the three event bits
    p_global_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_rdata[c*FLD_W + BIT_GLB] == |rsp_rdata[c*FLD_W + 1 +: NUM_EVT]));
  end

  if (DATA_W > USED_W) begin : g_rsvd
    assign status_word[DATA_W-1:USED_W] = '0;

    // R3: reserved bits above the last channel read as zero
    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_rdata[DATA_W-1:USED_W] == '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid & ~req_write;
      rsp_rdata <= hit_status ? status_word : '0;
    end
  end

endmodule

// File: rtl/dma_irq_line.sv
module dma_irq_line
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic [NUM_EVT-1:0][NUM_CH-1:0] flag_i,
  input  logic [NUM_EVT-1:0][NUM_CH-1:0] en_i,
  output logic [NUM_CH-1:0]              irq_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [NUM_EVT-1:0] hit;
    for (genvar k = 0; k < NUM_EVT; k++) begin : g_kind
      assign hit[k] = flag_i[k][c] & en_i[k][c];
    end
    assign irq_o[c] = |hit;
  end

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   evt_ht,
  input  logic [NUM_CH-1:0]   evt_tc,
  input  logic [NUM_CH-1:0]   evt_te,
  input  logic [NUM_CH-1:0]   ch_secure,
  input  logic [NUM_CH-1:0]   ch_priv,
  input  logic [NUM_CH-1:0]   en_ht,
  input  logic [NUM_CH-1:0]   en_tc,
  input  logic [NUM_CH-1:0]   en_te,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic                req_secure,
  input  logic                req_priv,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [NUM_CH-1:0]   irq
);

  logic [NUM_EVT-1:0][NUM_CH-1:0] set_v;
  logic [NUM_EVT-1:0][NUM_CH-1:0] clr_v;
  logic [NUM_EVT-1:0][NUM_CH-1:0] flag_v;
  logic [NUM_EVT-1:0][NUM_CH-1:0] en_v;

  assign set_v = {evt_te, evt_ht, evt_tc};
  assign en_v  = {en_te, en_ht, en_tc};

  dma_irq_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .flag_o (flag_v)
  );

  dma_irq_access #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_access (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_be     (req_be),
    .req_wdata  (req_wdata),
    .req_secure (req_secure),
    .req_priv   (req_priv),
    .ch_secure  (ch_secure),
    .ch_priv    (ch_priv),
    .flag_i     (flag_v),
    .clr_o      (clr_v),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  dma_irq_line #(.NUM_CH(NUM_CH)) u_line (
    .flag_i (flag_v),
    .en_i   (en_v),
    .irq_o  (irq)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R4: a non-secure read of a secure channel returns a zero field
    p_mask_secure_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_valid && !req_write && !req_secure && ch_secure[c]))
      |-> (rsp_rdata[c*FLD_W +: FLD_W] == '0));

    // R5: an unprivileged read of a privileged channel returns a zero field
    p_mask_priv_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_valid && !req_write && !req_priv && ch_priv[c]))
      |-> (rsp_rdata[c*FLD_W +: FLD_W] == '0));

    // R8: a clear from an access lacking trust leaves the channel untouched
    p_denied_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && ((!req_secure && ch_secure[c]) || (!req_priv && ch_priv[c]))
       && !evt_ht[c] && !evt_tc[c] && !evt_te[c])
      |=> ({flag_v[2][c], flag_v[1][c], flag_v[0][c]} ==
           $past({flag_v[2][c], flag_v[1][c], flag_v[0][c]})));
  end

endmodule

// File: tb/dma_irq_status_tb.sv
module dma_irq_status_tb;
  localparam int CLK_P = 10;
  localparam int N     = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] evt_ht = '0, evt_tc = '0, evt_te = '0;
  logic [N-1:0] ch_secure = '0, ch_priv = '0;
  logic [N-1:0] en_ht = '0, en_tc = '0, en_te = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        req_secure = 1'b0, req_priv = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [N-1:0] irq;

  int errors = 0;
  int checks = 0;
  string tag = "R3";

  // model flags: index 0 complete, 1 half, 2 error
  logic [N-1:0] m_tc = '0, m_ht = '0, m_te = '0;

  always #(CLK_P/2) clk = ~clk;

  dma_irq_status u_dut (
    .clk(clk), .rst_n(rst_n),
    .evt_ht(evt_ht), .evt_tc(evt_tc), .evt_te(evt_te),
    .ch_secure(ch_secure), .ch_priv(ch_priv),
    .en_ht(en_ht), .en_tc(en_tc), .en_te(en_te),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata),
    .req_secure(req_secure), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  function automatic logic ok_access(input int c, input logic s, input logic p);
    return (s || !ch_secure[c]) && (p || !ch_priv[c]);
  endfunction

  function automatic logic [31:0] exp_status(input logic s, input logic p);
    logic [31:0] w = '0;
    for (int c = 0; c < N; c++) begin
      if (ok_access(c, s, p)) begin
        w[4*c+1] = m_tc[c];
        w[4*c+2] = m_ht[c];
        w[4*c+3] = m_te[c];
        w[4*c]   = m_tc[c] | m_ht[c] | m_te[c];
      end
    end
    return w;
  endfunction

  function automatic logic [N-1:0] exp_irq();
    return (m_tc & en_tc) | (m_ht & en_ht) | (m_te & en_te);
  endfunction

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  // one clock: model update at the edge, output checks at the following negedge
  task automatic step();
    logic        ev;
    logic [31:0] er;
    logic        full;
    @(posedge clk);
    full = (req_be == 4'hF);
    ev = req_valid && !req_write;
    er = (ev && full && req_addr == 4'h0) ? exp_status(req_secure, req_priv) : 32'h0;
    for (int c = 0; c < N; c++) begin
      logic cl_tc, cl_ht, cl_te, hit;
      hit = req_valid && req_write && full && req_addr == 4'h4 && ok_access(c, req_secure, req_priv);
      cl_tc = hit && (req_wdata[4*c] || req_wdata[4*c+1]);
      cl_ht = hit && (req_wdata[4*c] || req_wdata[4*c+2]);
      cl_te = hit && (req_wdata[4*c] || req_wdata[4*c+3]);
      m_tc[c] = evt_tc[c] | (m_tc[c] & !cl_tc);
      m_ht[c] = evt_ht[c] | (m_ht[c] & !cl_ht);
      m_te[c] = evt_te[c] | (m_te[c] & !cl_te);
    end
    @(negedge clk);
    req_valid = 1'b0;
    evt_ht = '0; evt_tc = '0; evt_te = '0;
    check({tag, " rsp_valid"}, {31'h0, rsp_valid}, {31'h0, ev});
    if (ev) check({tag, " rdata"}, rsp_rdata, er);
    check("R9 irq", {25'h0, irq}, {25'h0, exp_irq()});
  endtask

  task automatic rd(input logic s, input logic p, input logic [3:0] a, input logic [3:0] be);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
    req_secure = s; req_priv = p; req_wdata = '0;
    step();
  endtask

  task automatic wr(input logic s, input logic p, input logic [3:0] a, input logic [3:0] be,
                    input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be;
    req_secure = s; req_priv = p; req_wdata = d;
    step();
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 irq", {25'h0, irq}, 25'h0);
    tag = "R1"; rd(1, 1, 4'h0, 4'hF);
    check("R1 status", rsp_rdata, 32'h0);

    // R2/R3: events in secure+privileged channel 0 and plain channel 6
    ch_secure[0] = 1; ch_priv[0] = 1;
    evt_tc[0] = 1; evt_te[6] = 1;
    tag = "R2"; step();
    tag = "R3"; rd(1, 1, 4'h0, 4'hF);
    check("R3 layout", rsp_rdata, 32'h0900_0003);

    // R4: non-secure privileged read hides channel 0
    tag = "R4"; rd(0, 1, 4'h0, 4'hF);
    check("R4 secure masked", rsp_rdata, 32'h0900_0000);

    // R5: unprivileged read hides privileged channels 0 and 6
    ch_priv[6] = 1;
    tag = "R5"; rd(1, 0, 4'h0, 4'hF);
    check("R5 priv masked", rsp_rdata, 32'h0);

    // R8: non-secure privileged clear of everything: ch0 kept, ch6 cleared
    tag = "R8"; wr(0, 1, 4'h4, 4'hF, 32'h0FFF_FFFF);
    rd(1, 1, 4'h0, 4'hF);
    check("R8 gated clear", rsp_rdata, 32'h0000_0003);
    tag = "R8"; wr(1, 0, 4'h4, 4'hF, 32'h0000_000F);
    rd(1, 1, 4'h0, 4'hF);
    check("R8 unpriv denied", rsp_rdata, 32'h0000_0003);

    // R6: individual clears
    tag = "R6"; wr(1, 1, 4'h4, 4'hF, 32'h0000_0002);
    rd(1, 1, 4'h0, 4'hF);
    check("R6 clear tc ch0", rsp_rdata, 32'h0);
    evt_ht[2] = 1; evt_te[2] = 1; step();
    wr(0, 0, 4'h4, 4'hF, 32'h0000_0400);
    rd(0, 0, 4'h0, 4'hF);
    check("R6 clear ht ch2 only", rsp_rdata, 32'h0000_0900);

    // R7: global clear
    tag = "R7"; wr(0, 0, 4'h4, 4'hF, 32'h0000_0100);
    rd(0, 0, 4'h0, 4'hF);
    check("R7 global clear", rsp_rdata, 32'h0);

    // R9: enables
    en_te[3] = 1; evt_ht[3] = 1;
    tag = "R9"; step();
    check("R9 wrong enable", {31'h0, irq[3]}, 32'h0);
    en_ht[3] = 1; step();
    check("R9 enabled", {31'h0, irq[3]}, 32'h1);
    en_ht[3] = 0; en_te[3] = 0;

    // R10: set wins over clear in the same cycle
    evt_ht[3] = 1;
    tag = "R10"; wr(0, 0, 4'h4, 4'hF, 32'h0000_F000);
    rd(0, 0, 4'h0, 4'hF);
    check("R10 set wins", rsp_rdata, 32'h0000_5000);

    // R11: partial accesses
    tag = "R11"; rd(0, 0, 4'h0, 4'h7);
    check("R11 partial read", rsp_rdata, 32'h0);
    wr(0, 0, 4'h4, 4'h3, 32'hFFFF_FFFF);
    rd(0, 0, 4'h0, 4'hF);
    check("R11 partial write", rsp_rdata, 32'h0000_5000);

    // R12: clear word reads zero, zero write and status write are no-ops
    tag = "R12"; rd(1, 1, 4'h4, 4'hF);
    check("R12 clear reads 0", rsp_rdata, 32'h0);
    wr(1, 1, 4'h4, 4'hF, 32'h0);
    wr(1, 1, 4'h0, 4'hF, 32'hFFFF_FFFF);
    rd(1, 1, 4'h0, 4'hF);
    check("R12 no-op writes", rsp_rdata, 32'h0000_5000);

    // random mix
    tag = "R2 R3 random";
    for (int i = 0; i < 600; i++) begin
      int sel;
      evt_ht = N'($urandom) & N'($urandom);
      evt_tc = N'($urandom) & N'($urandom);
      evt_te = N'($urandom) & N'($urandom) & N'($urandom);
      if (($urandom % 8) == 0) begin
        ch_secure = N'($urandom); ch_priv = N'($urandom);
      end
      en_ht = N'($urandom); en_tc = N'($urandom); en_te = N'($urandom);
      sel = $urandom % 10;
      if (sel < 4)
        rd(1'($urandom), 1'($urandom), 4'h0, (($urandom % 6) == 0) ? 4'($urandom) : 4'hF);
      else if (sel < 8)
        wr(1'($urandom), 1'($urandom), (($urandom % 5) == 0) ? 4'h0 : 4'h4,
           (($urandom % 6) == 0) ? 4'($urandom) : 4'hF, $urandom & $urandom);
      else if (sel == 8)
        rd(1'($urandom), 1'($urandom), 4'($urandom), 4'hF);
      else
        step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule